// File: doc/BRIEF.md
# Byte Bus Slave with Prioritised Overlay Windows

This block answers single-byte requests on an 8-bit address, 8-bit data bus. Behind the bus sits a 256-byte main memory. Two address windows lie on top of that memory, and each is an inclusive range set by parameters. Window 0 leads to a small I/O block. It has four input bytes, sampled from pins, and two output bytes, which are registered and drive pins. Window 1 leads to a small scratch memory. A request that falls inside a window never touches the main memory.

Each request is a one-cycle strobe. The response comes one cycle later: a valid pulse, the read data and a 2-bit status code. The I/O map is not symmetric. All four input bytes can be read at the top of the address space, but only the upper two addresses accept writes, and a write there goes to the output bytes. Illegal I/O accesses report a status code and change no state.

Top module: `ovl_bus_slave`

## Requirements
- R1: After reset every main-memory byte reads 0, both output bytes are 0 and `rsp_valid` is low.
- R2: A write to an address outside both windows updates that main-memory byte at the strobe edge. A later read of the address returns the written byte with status 00.
- R3: A window matches when first <= address <= last, with both ends included. Where windows overlap, window 0 (the I/O block) is chosen over window 1 (scratch), and an address outside both goes to main memory.
- R4: A write inside a window lands in the overlay target, and a read inside a window returns data from that target rather than from main memory.
- R5: The scratch target is indexed by the address modulo its size, 2**SCR_AW bytes.
- R6: A read of 0xFC..0xFF returns input byte (address-0xFC), and byte k is taken from `in_pins[8k+7:8k]`. Input pins are registered every cycle, so a read returns the value the pins had at the edge before the strobe edge.
- R7: A write to 0xFE/0xFF sets output byte (address-0xFE), which drives `out_pins[8j+7:8j]`. A read of 0xFE/0xFF returns input bytes 2/3, never the output bytes.
- R8: A write to 0xFC or 0xFD returns status 10, read data 0, and leaves the output bytes unchanged.
- R9: Any I/O-window access below 0xFC, read or write, returns status 01 with read data 0 and changes no state.
- R10: Every strobe yields exactly one `rsp_valid` pulse on the next cycle, and a cycle without a strobe yields none. A write responds with read data 0. When both strobes are high, the request is treated as a write.
- R11: If the input pins change in the same cycle that a read strobe addresses an input byte, the read returns the previous pin value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | 8 | Request byte address |
| req_wdata | input | 8 | Write data |
| req_rd | input | 1 | Read strobe, one cycle |
| req_wr | input | 1 | Write strobe, one cycle |
| rsp_rdata | output | 8 | Registered read data |
| rsp_valid | output | 1 | Response pulse, one cycle after a strobe |
| rsp_err | output | 2 | Status: 00 ok, 01 outside I/O map, 10 write to input-only byte |
| in_pins | input | 32 | Four external input bytes |
| out_pins | output | 16 | Two registered output bytes |

## Verification
The input sampler runs every cycle, so pin sampling and a read of an input byte can happen in the same cycle. The bench provokes this by changing `in_pins` on the same falling edge that raises a read strobe at 0xFC. It then requires the old byte in the response, and the new byte on the next read. A second pairing is a write strobe arriving together with a read strobe. The bench judges that the write takes effect and the response carries zero data. In a third case, 0xFC..0xFD lie inside both windows; the sweep judges that the I/O block answers there and the scratch contents stay hidden.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int AW        = 8;
  localparam int DW        = 8;
  localparam int SPACE     = 1 << AW;
  localparam int IN_BYTES  = 4;
  localparam int OUT_BYTES = 2;
  localparam int INW       = $clog2(IN_BYTES);
  localparam int OUTW      = (OUT_BYTES > 1) ? $clog2(OUT_BYTES) : 1;
  localparam logic [AW-1:0] IN_BASE  = AW'(SPACE - IN_BYTES);
  localparam logic [AW-1:0] OUT_BASE = AW'(SPACE - OUT_BYTES);

  typedef enum logic [1:0] {
    ERR_OK  = 2'b00,
    ERR_MAP = 2'b01,
    ERR_RO  = 2'b10
  } err_e;

  typedef enum logic [1:0] {
    TGT_RAM = 2'd0,
    TGT_IO  = 2'd1,
    TGT_SCR = 2'd2
  } tgt_e;

  function automatic logic in_range(logic [AW-1:0] a, logic [AW-1:0] lo,
                                    logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [INW-1:0] in_idx(logic [AW-1:0] a);
    return INW'(a - IN_BASE);
  endfunction

  function automatic logic [OUTW-1:0] out_idx(logic [AW-1:0] a);
    return OUTW'(a - OUT_BASE);
  endfunction

  function automatic err_e io_status(logic rd, logic wr, logic [AW-1:0] a);
    if (wr) begin
      if (a < IN_BASE)       return ERR_MAP;
      else if (a < OUT_BASE) return ERR_RO;
      else                   return ERR_OK;
    end else if (rd) begin
      if (a < IN_BASE)       return ERR_MAP;
      else                   return ERR_OK;
    end
    return ERR_OK;
  endfunction
endpackage

// File: rtl/ovl_decode.sv
module ovl_decode
  import ovl_pkg::*;
#(
  parameter int NWIN = 2,
  parameter logic [NWIN-1:0][AW-1:0] FIRSTS = '0,
  parameter logic [NWIN-1:0][AW-1:0] LASTS  = '0,
  localparam int WW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [AW-1:0] addr,
  output logic [NWIN-1:0] hit,
  output logic            any_hit,
  output logic [WW-1:0]   win
);
  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign hit[g] = in_range(addr, FIRSTS[g], LASTS[g]);
  end

  always_comb begin
    any_hit = 1'b0;
    win     = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        win     = WW'(i);
      end
    end
  end
endmodule

// File: rtl/ovl_mem.sv
module ovl_mem
  import ovl_pkg::*;
#(
  parameter int IDXW  = 8,
  localparam int DEPTH = 1 << IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/ovl_io.sv
module ovl_io
  import ovl_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel,
  input  logic                    rd,
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  input  logic [IN_BYTES*DW-1:0]  in_pins,
  output logic [OUT_BYTES*DW-1:0] out_pins,
  output logic [DW-1:0]           rdata,
  output err_e                    status,
  output logic                    io_we
);
  logic [DW-1:0] in_q  [IN_BYTES];
  logic [DW-1:0] out_q [OUT_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < IN_BYTES; i++) in_q[i] <= '0;
    end else begin
      for (int i = 0; i < IN_BYTES; i++) in_q[i] <= in_pins[i*DW +: DW];
    end
  end

  assign status = sel ? io_status(rd, wr, addr) : ERR_OK;
  assign io_we  = sel && wr && (status == ERR_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < OUT_BYTES; j++) out_q[j] <= '0;
    end else if (io_we) begin
      out_q[out_idx(addr)] <= wdata;
    end
  end

  for (genvar g = 0; g < OUT_BYTES; g++) begin : g_out
    assign out_pins[g*DW +: DW] = out_q[g];
  end

  assign rdata = (sel && rd && !wr && status == ERR_OK) ? in_q[in_idx(addr)] : '0;
endmodule

// File: rtl/ovl_bus_slave.sv
module ovl_bus_slave
  import ovl_pkg::*;
#(
  parameter logic [7:0] WIN0_FIRST = 8'hFC,
  parameter logic [7:0] WIN0_LAST  = 8'hFF,
  parameter logic [7:0] WIN1_FIRST = 8'hF0,
  parameter logic [7:0] WIN1_LAST  = 8'hF7,
  parameter int         SCR_AW     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  req_addr,
  input  logic [7:0]  req_wdata,
  input  logic        req_rd,
  input  logic        req_wr,
  output logic [7:0]  rsp_rdata,
  output logic        rsp_valid,
  output logic [1:0]  rsp_err,
  input  logic [31:0] in_pins,
  output logic [15:0] out_pins
);
  localparam int NWIN = 2;
  localparam int WW   = 1;

  logic            acc_wr, acc_rd, acc_any;
  logic [NWIN-1:0] win_hit;
  logic            win_any;
  logic [WW-1:0]   win_sel;
  tgt_e            tgt;
  logic            ram_we, scr_we, io_we;
  logic [DW-1:0]   ram_rdata, scr_rdata, io_rdata, rd_mux;
  err_e            io_err;

  assign acc_wr  = req_wr;
  assign acc_rd  = req_rd && !req_wr;
  assign acc_any = req_rd || req_wr;

  ovl_decode #(
    .NWIN  (NWIN),
    .FIRSTS({WIN1_FIRST, WIN0_FIRST}),
    .LASTS ({WIN1_LAST,  WIN0_LAST})
  ) u_dec (
    .addr   (req_addr),
    .hit    (win_hit),
    .any_hit(win_any),
    .win    (win_sel)
  );

  always_comb begin
    if (!win_any)          tgt = TGT_RAM;
    else if (win_sel == 0) tgt = TGT_IO;
    else                   tgt = TGT_SCR;
  end

  assign ram_we = acc_wr && (tgt == TGT_RAM);
  assign scr_we = acc_wr && (tgt == TGT_SCR);

  ovl_mem #(.IDXW(AW)) u_ram (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (ram_we),
    .idx  (req_addr),
    .wdata(req_wdata),
    .rdata(ram_rdata)
  );

  ovl_mem #(.IDXW(SCR_AW)) u_scr (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (scr_we),
    .idx  (req_addr[SCR_AW-1:0]),
    .wdata(req_wdata),
    .rdata(scr_rdata)
  );

  ovl_io u_io (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (tgt == TGT_IO),
    .rd      (acc_rd),
    .wr      (acc_wr),
    .addr    (req_addr),
    .wdata   (req_wdata),
    .in_pins (in_pins),
    .out_pins(out_pins),
    .rdata   (io_rdata),
    .status  (io_err),
    .io_we   (io_we)
  );

  always_comb begin
    unique case (tgt)
      TGT_IO:  rd_mux = io_rdata;
      TGT_SCR: rd_mux = scr_rdata;
      default: rd_mux = ram_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= ERR_OK;
    end else begin
      rsp_valid <= acc_any;
      rsp_rdata <= (acc_rd && io_err == ERR_OK) ? rd_mux : '0;
      rsp_err   <= acc_any ? io_err : ERR_OK;
    end
  end
endmodule

module ovl_bus_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_rd,
  input logic        req_wr,
  input logic        rsp_valid,
  input logic [7:0]  rsp_rdata,
  input logic [1:0]  rsp_err,
  input logic        ram_we,
  input logic        scr_we,
  input logic        io_we,
  input logic [1:0]  io_err,
  input logic [15:0] out_pins
);
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd || req_wr) |=> rsp_valid);
  p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_rd || req_wr) |=> !rsp_valid);
  p_wr_zero_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr |=> (rsp_rdata == 8'h00));
  p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, scr_we, io_we}));
  p_no_wr_no_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_wr |-> !(ram_we || scr_we || io_we));
  p_err_keeps_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_err != 2'b00) |=> $stable(out_pins));
  p_err_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err != 2'b00) |-> (rsp_rdata == 8'h00));
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !io_we |=> $stable(out_pins));
endmodule

bind ovl_bus_slave ovl_bus_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_rd   (req_rd),
  .req_wr   (req_wr),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata),
  .rsp_err  (rsp_err),
  .ram_we   (ram_we),
  .scr_we   (scr_we),
  .io_we    (io_we),
  .io_err   (io_err),
  .out_pins (out_pins)
);

// File: tb/ovl_bus_slave_tb.sv
`timescale 1ns/1ps
module ovl_bus_slave_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  req_addr = 0, req_wdata = 0;
  logic        req_rd = 0, req_wr = 0;
  logic [7:0]  rsp_rdata;
  logic        rsp_valid;
  logic [1:0]  rsp_err;
  logic [31:0] in_pins = 0;
  logic [15:0] out_pins;

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] ram_m [256];
  logic [7:0] scr_m [16];
  logic [7:0] out_m [2];

  always #5 clk = ~clk;

  ovl_bus_slave #(
    .WIN0_FIRST(8'hF8), .WIN0_LAST(8'hFF),
    .WIN1_FIRST(8'hF0), .WIN1_LAST(8'hFD),
    .SCR_AW(4)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rd(req_rd), .req_wr(req_wr), .rsp_rdata(rsp_rdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .in_pins(in_pins),
    .out_pins(out_pins)
  );

  // target: 0 ram, 1 io, 2 scratch (bench configuration)
  function automatic int tgt_of(logic [7:0] a);
    if (a >= 8'hF8) return 1;
    if (a >= 8'hF0 && a <= 8'hFD) return 2;
    return 0;
  endfunction

  function automatic logic [1:0] exp_err(bit w, logic [7:0] a);
    if (tgt_of(a) != 1) return 2'b00;
    if (a < 8'hFC) return 2'b01;
    if (w && a < 8'hFE) return 2'b10;
    return 2'b00;
  endfunction

  function automatic string tag_of(bit w, logic [7:0] a);
    int t = tgt_of(a);
    if (t == 0) return "R2";
    if (t == 2) return w ? "R4" : "R5";
    if (a < 8'hFC) return "R9";
    if (w) return (a < 8'hFE) ? "R8" : "R7";
    return "R6";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(bit r, bit w, logic [7:0] a, logic [7:0] d, string tag);
    logic [1:0] e;
    logic [7:0] exp_d;
    int t;
    @(negedge clk);
    req_rd = r; req_wr = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_rd = 0; req_wr = 0;
    t = tgt_of(a);
    e = exp_err(w, a);
    exp_d = 8'h00;
    if (!w && e == 2'b00) begin
      if (t == 1) exp_d = in_pins[(a - 8'hFC)*8 +: 8];
      else if (t == 2) exp_d = scr_m[a[3:0]];
      else exp_d = ram_m[a];
    end
    if (w && e == 2'b00) begin
      if (t == 1) out_m[a - 8'hFE] = d;
      else if (t == 2) scr_m[a[3:0]] = d;
      else ram_m[a] = d;
    end
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " err"}, 32'(rsp_err), 32'(e));
    check({tag, " data"}, 32'(rsp_rdata), 32'(exp_d));
    check({tag, " out"}, 32'(out_pins), {16'h0, out_m[1], out_m[0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) ram_m[i] = 0;
    for (int i = 0; i < 16; i++) scr_m[i] = 0;
    out_m[0] = 0; out_m[1] = 0;
    in_pins = 32'hD4C3B2A1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 valid", 32'(rsp_valid), 0);
    check("R1 out", 32'(out_pins), 0);
    for (int a = 0; a < 8'hF0; a++) access(1, 0, 8'(a), 0, "R1");

    // write sweep then read sweep over the whole space
    for (int a = 0; a < 256; a++)
      access(0, 1, 8'(a), 8'(a * 37 + 11), tag_of(1, 8'(a)));
    for (int a = 0; a < 256; a++)
      access(1, 0, 8'(a), 0, tag_of(0, 8'(a)));

    // R3: inclusive edges and window-0 priority over overlap
    access(1, 0, 8'hEF, 0, "R3");
    access(1, 0, 8'hF0, 0, "R3");
    access(1, 0, 8'hF7, 0, "R3");
    access(1, 0, 8'hFD, 0, "R3");
    access(0, 1, 8'hFD, 8'h99, "R3");

    // R6: several input patterns
    for (int p = 0; p < 3; p++) begin
      @(negedge clk);
      in_pins = {8'(p*17+3), 8'(p*29+5), 8'(p*43+7), 8'(p*59+9)};
      for (int a = 8'hFC; a <= 8'hFF; a++) access(1, 0, 8'(a), 0, "R6");
    end

    // R7: output writes then read-back of inputs at the same addresses
    access(0, 1, 8'hFE, 8'h3C, "R7");
    access(0, 1, 8'hFF, 8'hC3, "R7");
    access(1, 0, 8'hFE, 0, "R7");
    access(1, 0, 8'hFF, 0, "R7");
    // R8 / R9: illegal accesses change nothing
    access(0, 1, 8'hFC, 8'h11, "R8");
    access(0, 1, 8'hF9, 8'h22, "R9");
    access(1, 0, 8'hFB, 0, "R9");

    // R10: both strobes act as a write; idle cycle gives no pulse
    access(1, 1, 8'h20, 8'h5A, "R10");
    access(1, 0, 8'h20, 0, "R10");
    @(negedge clk);
    check("R10 idle valid", 32'(rsp_valid), 0);

    // R11: pins change in the same cycle as the read strobe
    begin
      logic [7:0] old_b;
      old_b = in_pins[7:0];
      @(negedge clk);
      req_rd = 1; req_addr = 8'hFC;
      in_pins[7:0] = ~old_b;
      @(negedge clk);
      req_rd = 0;
      check("R11 old byte", 32'(rsp_rdata), 32'(old_b));
      access(1, 0, 8'hFC, 0, "R11");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule